// File: doc/BRIEF.md
# Synchronous SRAM Core with Selectable Read Latency

This block is the storage core of a synchronous static RAM. Address, chip selects, write controls and write data are all taken on the rising clock edge. A write is committed on that same edge. A read returns one 32-bit word on a data path split into four 8-bit lanes. The address comes from an external burst sequencer, which presents a new word address on each clock. The core therefore streams one word per cycle, whether the addresses are sequential or random.

A static mode input sets the read latency. In flow-through mode the array output goes straight to the read-data port, so the word is available one edge after capture. In pipelined mode the word is first held in an output register, which adds one cycle. For a four-word burst this gives 2-1-1-1 clocks in flow-through mode and 3-1-1-1 clocks in pipelined mode.

Output drive uses single-cycle deselect. A deselect turns the drivers off straight from the input register stage, one stage before a read would reach the outputs. The data bus is modelled as separate input and output ports plus a drive-enable signal. An output enable and a sleep input both gate that drive-enable asynchronously. While sleep is high, the core also ignores commands.

Top module: `sram_core`

## Requirements
- R1: After reset is released, `dq_oe` is low until a read has been captured.
- R2: The core is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. With any other chip-select combination the cycle is a deselect: nothing is written and no read data is driven.
- R3: Flow-through mode (`pipe_mode`=0): a read captured at edge k drives `dq_oe`=1 and `rdata`=word at `addr` in the cycle that follows edge k.
- R4: Pipelined mode (`pipe_mode`=1): a read captured at edge k drives its word in the cycle that follows edge k+1.
- R5: Reads presented on consecutive clocks each return their own word on consecutive cycles. This holds in both modes.
- R6: With `gwr_n`=1 and `bwe_n`=0, lane i (bits 8i+7..8i) is written exactly when `bsel_n[i]`=0, and the other lanes keep their contents. If no `bsel_n` bit is low, the cycle is a read.
- R7: `gwr_n`=0 writes all four lanes, whatever the values of `bwe_n` and `bsel_n`.
- R8: A write takes effect on the edge that captures it, so a read of the same address on the next clock returns the new word. A write cycle never drives read data of its own. In pipelined mode, a write that follows a read leaves that read's word driven.
- R9: A deselect captured at edge k forces `dq_oe` low in the cycle after edge k. In pipelined mode this also suppresses the word of a read captured at edge k-1.
- R10: `oe_n`=1 forces `dq_oe` low asynchronously. It has no effect on memory contents or on later reads.
- R11: While `sleep`=1, commands are ignored (no write happens), `dq_oe` is low, and the stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through reads |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| addr | input | AW (6) | Word address from the burst sequencer |
| gwr_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NB (4) | Per-lane byte selects, active low |
| wdata | input | NB*LW (32) | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| rdata | output | NB*LW (32) | Read data |
| dq_oe | output | 1 | Read data is being driven |

## Verification
The hardest case to reach is the single-cycle-deselect cut-off in pipelined mode. A read's word has been loaded into the output register, but a deselect captured one edge later has to hide it. Reaching this needs a read followed directly by a deselect. It also needs the contrasting case, a read followed by a write, which must leave the word visible. The stimulus issues both pairs back to back in pipelined mode. The scoreboard then revises the expectation already queued for the earlier read, so that it reflects the command that arrives after it.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;

  // Command held in the input register stage
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } op_e;

endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
  import sram_core_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          cs1_n,
  input  logic          cs2,
  input  logic          cs3_n,
  input  logic          gwr_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bsel_n,
  input  logic [AW-1:0] addr,
  input  logic          sleep,
  output op_e           op_now,
  output logic [NB-1:0] wr_mask,
  output op_e           op_q,
  output logic [AW-1:0] addr_q
);

  logic          sel;
  logic [NB-1:0] lane_req;
  op_e           op_d;
  logic [AW-1:0] addr_d;
  logic          addr_en;

  // decode of the command presented this cycle
  always_comb begin
    sel = !cs1_n && cs2 && !cs3_n;
    if (!gwr_n)      lane_req = {NB{1'b1}};
    else if (!bwe_n) lane_req = ~bsel_n;
    else             lane_req = '0;

    if (sleep)            op_now = OP_NONE;
    else if (!sel)        op_now = OP_DESEL;
    else if (|lane_req)   op_now = OP_WRITE;
    else                  op_now = OP_READ;

    wr_mask = (op_now == OP_WRITE) ? lane_req : '0;
  end

  // next-state for the input register stage
  always_comb begin
    op_d    = op_now;
    addr_en = (op_now == OP_READ);
    addr_d  = addr_en ? addr : addr_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic           clk,
  input  logic [NB-1:0]  wr_mask,
  input  logic [AW-1:0]  wr_addr,
  input  logic [NB*LW-1:0] wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [NB*LW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_mask[g]) store[wr_addr] <= wr_data[g*LW +: LW];
    end

    assign rd_data[g*LW +: LW] = store[rd_addr];
  end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_core_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          pipe_mode,
  input  op_e           op_q,
  input  logic [DW-1:0] arr_rd,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [DW-1:0] rdata,
  output logic          dq_oe
);

  logic [DW-1:0] dout_q, dout_d;
  logic          dout_en;
  logic          drv_q, drv_d;
  logic          drv_int;

  // output register next-state with explicit clock enable
  always_comb begin
    dout_en = (op_q == OP_READ);
    dout_d  = dout_en ? arr_rd : dout_q;
    drv_d   = (op_q == OP_READ);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      dout_q <= '0;
      drv_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      drv_q  <= drv_d;
    end
  end

  // read data leaves two stages deep when pipelined, deselect only one
  always_comb begin
    if (pipe_mode) begin
      rdata   = dout_q;
      drv_int = drv_q && (op_q != OP_DESEL);
    end else begin
      rdata   = arr_rd;
      drv_int = (op_q == OP_READ);
    end
    dq_oe = drv_int && !oe_n && !sleep;
  end

  AST_PIPE_DATA: assert property (@(posedge clk) disable iff (!rst_q)
    (pipe_mode && op_q == OP_READ) |=> (!pipe_mode || rdata == $past(arr_rd))); // R4

endmodule

// File: rtl/sram_core.sv
module sram_core
  import sram_core_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic [AW-1:0]    addr,
  input  logic             gwr_n,
  input  logic             bwe_n,
  input  logic [NB-1:0]    bsel_n,
  input  logic [NB*LW-1:0] wdata,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [NB*LW-1:0] rdata,
  output logic             dq_oe
);

  localparam int DW = NB * LW;

  logic [1:0]    rst_sync;
  logic          rst_q;
  op_e           op_now;
  op_e           op_q;
  logic [NB-1:0] wr_mask;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] arr_rd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  sram_in_stage #(.AW(AW), .NB(NB)) i_in (
    .clk    (clk),
    .rst_q  (rst_q),
    .cs1_n  (cs1_n),
    .cs2    (cs2),
    .cs3_n  (cs3_n),
    .gwr_n  (gwr_n),
    .bwe_n  (bwe_n),
    .bsel_n (bsel_n),
    .addr   (addr),
    .sleep  (sleep),
    .op_now (op_now),
    .wr_mask(wr_mask),
    .op_q   (op_q),
    .addr_q (addr_q)
  );

  sram_array #(.AW(AW), .NB(NB), .LW(LW)) i_arr (
    .clk    (clk),
    .wr_mask(wr_mask),
    .wr_addr(addr),
    .wr_data(wdata),
    .rd_addr(addr_q),
    .rd_data(arr_rd)
  );

  sram_out_stage #(.DW(DW)) i_out (
    .clk      (clk),
    .rst_q    (rst_q),
    .pipe_mode(pipe_mode),
    .op_q     (op_q),
    .arr_rd   (arr_rd),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .rdata    (rdata),
    .dq_oe    (dq_oe)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    (!rst_q) |=> (!dq_oe || rst_q)); // R1

  AST_FT_DRIVE: assert property (@(posedge clk) disable iff (!rst_q)
    (op_now == OP_READ && !pipe_mode) |=> (pipe_mode || oe_n || sleep || dq_oe)); // R3

  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_q)
    (op_now == OP_DESEL) |=> !dq_oe); // R9

  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_q)
    (!gwr_n && !cs1_n && cs2 && !cs3_n && !sleep) |-> (&wr_mask)); // R7

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_q)
    oe_n |-> !dq_oe); // R10

  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    sleep |-> (wr_mask == '0 && !dq_oe)); // R11

endmodule

// File: tb/test_sram_core.sv
`timescale 1ns/1ps
module test_sram_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pipe_mode;
  logic        cs1_n, cs2, cs3_n;
  logic [5:0]  addr;
  logic        gwr_n, bwe_n;
  logic [3:0]  bsel_n;
  logic [31:0] wdata;
  logic        oe_n, sleep;
  logic [31:0] rdata;
  logic        dq_oe;

  always #4 clk = ~clk;   // 125 MHz

  sram_core i_sram_core (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .addr(addr),
    .gwr_n(gwr_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .wdata(wdata),
    .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .dq_oe(dq_oe)
  );

  typedef struct {
    int          due;
    logic        oe;
    logic [31:0] data;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] ref_mem [64];
  int          ecnt   = 0;
  int          checks = 0;
  int          fails  = 0;
  logic        pm     = 1'b0;
  logic        ended  = 1'b0;

  always @(posedge clk) ecnt <= ecnt + 1;

  // monitor: compare outputs against due items, away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= ecnt) begin
      item_t it;
      it = sb.pop_front();
      if (it.due == ecnt) begin
        checks++;
        if (dq_oe !== it.oe || (it.oe && rdata !== it.data)) begin
          fails++;
          $display("FAIL %s: dq_oe=%0b rdata=%h expected dq_oe=%0b rdata=%h",
                   it.tag, dq_oe, rdata, it.oe, it.data);
        end
      end
    end
  end

  function automatic logic [31:0] pat(input int a);
    pat = {8'(a), 8'(a + 8'h40), 8'(a ^ 8'h5A), ~8'(a)};
  endfunction

  // driver: one command per clock, expected results pushed into the scoreboard
  task automatic step(input logic [2:0] cs, input logic gw_n, input logic bw_n,
                      input logic [3:0] bs_n, input int a, input logic [31:0] d,
                      input logic oen, input logic slp, input string tag);
    logic       sel, wr, rd, des;
    logic [3:0] mask;
    logic [31:0] rv;
    int         k;
    item_t      it;
    @(negedge clk);
    #2;
    pipe_mode = pm;
    {cs1_n, cs2, cs3_n} = cs;
    gwr_n = gw_n; bwe_n = bw_n; bsel_n = bs_n;
    addr = 6'(a); wdata = d; oe_n = oen; sleep = slp;
    k    = ecnt + 1;
    sel  = (cs == 3'b010);
    mask = !gw_n ? 4'hF : (!bw_n ? ~bs_n : 4'h0);
    wr   = sel && !slp && (mask != 0);
    rd   = sel && !slp && (mask == 0);
    des  = !sel && !slp;
    rv   = ref_mem[a];
    if (wr)
      for (int i = 0; i < 4; i++)
        if (mask[i]) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
    if (pm) begin
      if (sb.size() > 0 && sb[$].due == k) begin
        it = sb.pop_back();
        if (it.oe && des) it.tag = {it.tag, "/R9"};
        if (it.oe && oen) it.tag = {it.tag, "/R10"};
        if (it.oe && slp) it.tag = {it.tag, "/R11"};
        it.oe = it.oe && !des && !oen && !slp;
        sb.push_back(it);
      end
      it = '{due: k + 1, oe: rd, data: rv, tag: tag};
      sb.push_back(it);
    end else begin
      it = '{due: k, oe: rd && !oen, data: rv, tag: tag};
      sb.push_back(it);
    end
  endtask

  task automatic rd_w(input int a, input string tag);
    step(3'b010, 1'b1, 1'b1, 4'hF, a, 32'h0, 1'b0, 1'b0, tag);
  endtask
  task automatic gw_w(input int a, input logic [31:0] d, input string tag);
    step(3'b010, 1'b0, 1'b1, 4'h0, a, d, 1'b0, 1'b0, tag);
  endtask
  task automatic bw_w(input int a, input logic [3:0] bs, input logic [31:0] d, input string tag);
    step(3'b010, 1'b1, 1'b0, bs, a, d, 1'b0, 1'b0, tag);
  endtask
  task automatic ds_w(input string tag);
    step(3'b110, 1'b1, 1'b1, 4'hF, 0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic finish_up;
    if (!ended) begin
      ended = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; pipe_mode = 1'b0;
    {cs1_n, cs2, cs3_n} = 3'b110;
    addr = '0; gwr_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
    wdata = '0; oe_n = 1'b0; sleep = 1'b0;
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dq_oe !== 1'b0) begin
      fails++;
      $display("FAIL R1: dq_oe=%0b expected 0", dq_oe);
    end

    // flow-through mode: fill, burst read, lane writes
    pm = 1'b0;
    for (int a = 0; a < 8; a++) gw_w(a, pat(a), "R8");
    for (int a = 0; a < 4; a++) rd_w(a, "R3 R5");
    bw_w(2, 4'b0101, 32'hDEADBEEF, "R6");
    rd_w(2, "R6");
    bw_w(3, 4'b1111, 32'h12345678, "R6");          // no lane selected: read of 3
    step(3'b010, 1'b0, 1'b0, 4'b1110, 4, 32'hCAFEF00D, 1'b0, 1'b0, "R7");
    rd_w(4, "R7");
    gw_w(5, 32'h0BADC0DE, "R8");
    rd_w(5, "R8");
    // partial selects ignore writes and reads
    step(3'b110, 1'b0, 1'b1, 4'h0, 6, 32'h11111111, 1'b0, 1'b0, "R2");
    step(3'b000, 1'b0, 1'b1, 4'h0, 6, 32'h22222222, 1'b0, 1'b0, "R2");
    step(3'b011, 1'b0, 1'b1, 4'h0, 6, 32'h33333333, 1'b0, 1'b0, "R2");
    step(3'b011, 1'b1, 1'b1, 4'hF, 6, 32'h0, 1'b0, 1'b0, "R2");
    rd_w(6, "R2");
    ds_w("R9"); ds_w("R9");

    // pipelined mode
    pm = 1'b1;
    ds_w("R9"); ds_w("R9");
    for (int a = 4; a < 8; a++) rd_w(a, "R4 R5");
    rd_w(0, "R4 R5");
    rd_w(1, "R9");
    ds_w("R9");
    rd_w(2, "R8");
    gw_w(3, 32'hA1B2C3D4, "R8");
    rd_w(3, "R8");
    ds_w("R9");
    rd_w(0, "R10");
    step(3'b010, 1'b1, 1'b1, 4'hF, 1, 32'h0, 1'b1, 1'b0, "R10");
    rd_w(1, "R10");
    ds_w("R9");
    // sleep: write ignored, contents kept
    step(3'b010, 1'b0, 1'b1, 4'h0, 7, 32'hFFFF0000, 1'b0, 1'b1, "R11");
    step(3'b010, 1'b1, 1'b1, 4'hF, 7, 32'h0, 1'b0, 1'b1, "R11");
    rd_w(7, "R11");
    ds_w("R9");

    // back to flow-through
    pm = 1'b0;
    ds_w("R9");
    step(3'b010, 1'b1, 1'b1, 4'hF, 7, 32'h0, 1'b1, 1'b0, "R10");
    step(3'b010, 1'b1, 1'b1, 4'hF, 7, 32'h0, 1'b0, 1'b1, "R11");
    rd_w(7, "R11");
    rd_w(2, "R6");
    ds_w("R9"); ds_w("R9"); ds_w("R9");
    repeat (3) @(posedge clk);
    @(negedge clk);
    finish_up();
  end

endmodule